// File: doc/BRIEF.md
# Sampling ADC Digital Interface Model

This block is a synthesizable stand-in for the digital side of a 16-bit sampling converter. A host controller under test drives it exactly as it would drive the real converter. Pulling both chip-select and read/convert low takes a sample of the `sample_in` word, which stands in for the held analog level, and starts a conversion of fixed length. While that conversion runs, the busy output is low. When it ends, the result moves into an output register, and a host read then shows it on a 16-bit bus. The bus can be driven with the bytes in normal order or with the bytes swapped.

The bus has an output-enable that models the high-impedance state. When the enable is low, the bus itself reads zero. A parameter selects the result format: straight binary, or two's complement. A timing monitor watches the host for two faults. The first is a start strobe shorter than the minimum width. The second is read/convert held low too long after a start. Each fault produces a one-cycle pulse.

Top module: `adc_iface_model`

## Requirements
- R1: When `busy_n` is high and `cs_n` and `rc_n` are both low at a clock edge, a conversion starts at that edge. The value of `sample_in` at that edge is captured, and `busy_n` reads low after that edge.
- R2: After a start, `busy_n` stays low for exactly `CONV_CYCLES` clock cycles. At the edge where `busy_n` returns high, the output register takes the new result.
- R3: A start condition that arrives while a conversion runs is ignored. It captures no new sample and does not lengthen the busy time.
- R4: `data_oe` is high only while `cs_n` is low and `rc_n` is high. While `data_oe` is low, `data_o` reads all zeros, which stands in for high impedance.
- R5: Until a conversion finishes, a read shows the previous result. After reset, that previous result is zero.
- R6: With `byte_sel` low, `data_o[15:8]` carries result bits 15:8 and `data_o[7:0]` carries bits 7:0. With `byte_sel` high, the two bytes are swapped: `data_o[15:8]` carries result bits 7:0 and `data_o[7:0]` carries bits 15:8.
- R7: With `TWOS_COMP`=0, the result equals the captured sample (straight binary). With `TWOS_COMP`=1, the result is the captured sample with bit 15 inverted (two's complement).
- R8: Suppose a start strobe ends after it was seen low at N clock edges, counting the start edge, and N is less than `MIN_STROBE`. Then `short_o` pulses high for one cycle after the release edge. If N is at least `MIN_STROBE`, `short_o` stays low.
- R9: After a start, if `rc_n` is still low at edge number `MAX_RC_LOW`+1 (the start edge counts as 1), `long_o` pulses high for one cycle. If `rc_n` returns high earlier, `long_o` stays low.
- R10: While reset is held, and after it is released with no start, `busy_n` is high, `short_o` and `long_o` are low, and the output register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| rc_n | input | 1 | Read (high) / convert (low) |
| byte_sel | input | 1 | High swaps the two bytes on the bus |
| sample_in | input | 16 | Value that stands in for the held analog level |
| busy_n | output | 1 | Low while a conversion runs |
| data_o | output | 16 | Result bus, zero while disabled |
| data_oe | output | 1 | Bus enable (low = high impedance) |
| short_o | output | 1 | One-cycle pulse: start strobe too short |
| long_o | output | 1 | One-cycle pulse: read/convert held low too long |

## Verification
The assertions assume the host inputs change only between clock edges and stay at known levels once reset has been released. The bench meets this by driving every input on the falling edge. The stability check on the bus during a conversion also assumes that `byte_sel` does not move while the output is compared. The bench therefore changes `byte_sel` only while the bus is idle, and the assertion itself is qualified on `byte_sel` being stable. Attempted restarts are placed well inside the busy window, so the R2 length check stays meaningful.

// File: rtl/adc_iface_pkg.sv
package adc_iface_pkg;
  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } conv_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_iface_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(CONV_CYCLES - 1);

  conv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    start   = 1'b0;
    done    = 1'b0;
    case (state_q)
      CONV_IDLE: begin
        if (start_req) begin
          start   = 1'b1;
          state_d = CONV_RUN;
          cnt_d   = LOAD_V;
          cnt_en  = 1'b1;
        end
      end
      CONV_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          done    = 1'b1;
          state_d = CONV_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = CONV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CONV_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == CONV_RUN);
endmodule

// File: rtl/adc_out_path.sv
module adc_out_path
  import adc_iface_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter bit          TWOS_COMP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic              load_en,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              byte_sel,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  localparam int unsigned NBYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] held_q, res_q, res_fmt, lanes;

  generate
    if (TWOS_COMP) begin : g_twos
      assign res_fmt = {~held_q[DATA_W-1], held_q[DATA_W-2:0]};
    end else begin : g_bin
      assign res_fmt = held_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      res_q  <= '0;
    end else begin
      if (capture_en) held_q <= sample_in;
      if (load_en)    res_q  <= res_fmt;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lanes[b*BYTE_W +: BYTE_W] =
      byte_sel ? res_q[(NBYTES-1-b)*BYTE_W +: BYTE_W] : res_q[b*BYTE_W +: BYTE_W];
  end

  assign data_oe = !cs_n && rc_n;
  assign data_o  = data_oe ? lanes : '0;
endmodule

// File: rtl/adc_timing_mon.sv
module adc_timing_mon #(
  parameter int unsigned MIN_STROBE = 8,
  parameter int unsigned MAX_RC_LOW = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cs_n,
  input  logic rc_n,
  output logic short_o,
  output logic long_o
);
  localparam int unsigned RW = $clog2(MIN_STROBE + 1);
  localparam int unsigned HW = $clog2(MAX_RC_LOW + 1);
  localparam logic [RW-1:0] MIN_V = RW'(MIN_STROBE);
  localparam logic [HW-1:0] MAX_V = HW'(MAX_RC_LOW);

  logic          strobe_low;
  logic          in_strb_q, in_strb_d;
  logic [RW-1:0] run_q, run_d;
  logic          hold_trk_q, hold_trk_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          short_q, short_d, long_q, long_d;

  assign strobe_low = !cs_n && !rc_n;

  always_comb begin
    in_strb_d  = in_strb_q;
    run_d      = run_q;
    hold_trk_d = hold_trk_q;
    hold_d     = hold_q;
    short_d    = 1'b0;
    long_d     = 1'b0;
    if (start) begin
      in_strb_d  = 1'b1;
      run_d      = RW'(1);
      hold_trk_d = 1'b1;
      hold_d     = HW'(1);
    end else begin
      if (in_strb_q) begin
        if (strobe_low) begin
          if (run_q < MIN_V) run_d = run_q + 1'b1;
        end else begin
          in_strb_d = 1'b0;
          short_d   = (run_q < MIN_V);
        end
      end
      if (hold_trk_q) begin
        if (!rc_n) begin
          if (hold_q == MAX_V) begin
            long_d     = 1'b1;
            hold_trk_d = 1'b0;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end else begin
          hold_trk_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_strb_q  <= 1'b0;
      run_q      <= '0;
      hold_trk_q <= 1'b0;
      hold_q     <= '0;
      short_q    <= 1'b0;
      long_q     <= 1'b0;
    end else begin
      in_strb_q  <= in_strb_d;
      run_q      <= run_d;
      hold_trk_q <= hold_trk_d;
      hold_q     <= hold_d;
      short_q    <= short_d;
      long_q     <= long_d;
    end
  end

  assign short_o = short_q;
  assign long_o  = long_q;
endmodule

// File: rtl/adc_iface_model.sv
module adc_iface_model #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 1400,
  parameter int unsigned MIN_STROBE  = 8,
  parameter int unsigned MAX_RC_LOW  = 600,
  parameter bit          TWOS_COMP   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy_n,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              short_o,
  output logic              long_o
);
  logic start_req, start, busy, done;

  assign start_req = !cs_n && !rc_n;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .start(start), .busy(busy), .done(done)
  );

  adc_out_path #(.DATA_W(DATA_W), .TWOS_COMP(TWOS_COMP)) u_out (
    .clk(clk), .rst_n(rst_n), .capture_en(start), .load_en(done),
    .sample_in(sample_in), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel),
    .data_o(data_o), .data_oe(data_oe)
  );

  adc_timing_mon #(.MIN_STROBE(MIN_STROBE), .MAX_RC_LOW(MAX_RC_LOW)) u_mon (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .rc_n(rc_n),
    .short_o(short_o), .long_o(long_o)
  );

  assign busy_n = !busy;
endmodule

// File: rtl/adc_iface_chk.sv
module adc_iface_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 1400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rc_n,
  input logic              byte_sel,
  input logic              busy_n,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe,
  input logic              short_o,
  input logic              long_o
);
  localparam int unsigned LW = $clog2(CONV_CYCLES + 2);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (!busy_n)  low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !cs_n && !rc_n) |=> !busy_n); // R1
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (low_cnt < LW'(CONV_CYCLES))); // R2
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && low_cnt == LW'(CONV_CYCLES - 1)) |=> busy_n); // R3
  AST_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_o == '0)); // R4
  AST_CONV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_n |-> !data_oe); // R4
  AST_PREV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && $past(!busy_n) && data_oe && $past(data_oe) && $stable(byte_sel))
      |-> $stable(data_o)); // R5
  AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |-> $past(cs_n || rc_n)); // R8
  AST_LONG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    long_o |-> $past(!rc_n)); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({short_o, long_o})); // R8
endmodule

bind adc_iface_model adc_iface_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel),
  .busy_n(busy_n), .data_o(data_o), .data_oe(data_oe),
  .short_o(short_o), .long_o(long_o)
);

// File: tb/adc_iface_model_tb.sv
module adc_iface_model_tb;
  localparam int unsigned CONV = 20;
  localparam int unsigned MINS = 4;
  localparam int unsigned MAXL = 12;

  logic clk, rst_n, cs_n, rc_n, byte_sel;
  logic [15:0] sample_in, data_o, data_tc;
  logic busy_n, data_oe, short_o, long_o;
  logic busy_tc, oe_tc, short_tc, long_tc;

  int checks = 0, errors = 0, n_short = 0, n_long = 0;
  bit finished = 0;
  logic [15:0] exp_q[$], exp_tc_q[$];
  event rd_ev;

  adc_iface_model #(.CONV_CYCLES(CONV), .MIN_STROBE(MINS), .MAX_RC_LOW(MAXL), .TWOS_COMP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel),
    .sample_in(sample_in), .busy_n(busy_n), .data_o(data_o), .data_oe(data_oe),
    .short_o(short_o), .long_o(long_o));

  adc_iface_model #(.CONV_CYCLES(CONV), .MIN_STROBE(MINS), .MAX_RC_LOW(MAXL), .TWOS_COMP(1'b1)) u_dut_tc (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .byte_sel(byte_sel),
    .sample_in(sample_in), .busy_n(busy_tc), .data_o(data_tc), .data_oe(oe_tc),
    .short_o(short_tc), .long_o(long_tc));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (short_o) n_short++;
    if (long_o)  n_long++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] v, input logic sw);
    return sw ? {v[7:0], v[15:8]} : v;
  endfunction

  // Scoreboard monitor: pops an expected bus word on every read event
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) check(1'b0, "R5 scoreboard empty", 0, 1);
      else begin
        logic [15:0] e, et;
        e  = exp_q.pop_front();
        et = exp_tc_q.pop_front();
        check(data_o == e, "R1/R6 read value", data_o, e);
        check(data_tc == et, "R7 two's complement read", data_tc, et);
      end
    end
  end

  // Driver: one conversion, strobe of 'width' edges, optional restart attempt
  task automatic convert(input logic [15:0] s, input int width, input int restart_at,
                         input logic [15:0] prev, input logic sw);
    int lows = 0;
    @(negedge clk);
    sample_in = s; cs_n = 1'b0; rc_n = 1'b0;
    for (int i = 0; i < CONV + 4; i++) begin
      @(negedge clk);
      if (i == 0) check(busy_n == 1'b0, "R1 busy low after start", busy_n, 0);
      if (i == 0) sample_in = ~s;
      if (!busy_n) lows++;
      if (i + 1 == width) rc_n = 1'b1;
      if (i == width + 1 && !busy_n)
        check(data_o == prev, "R5 previous data during conversion", data_o, prev);
      if (restart_at > 0 && i == restart_at) rc_n = 1'b0;
      if (restart_at > 0 && i == restart_at + 2) rc_n = 1'b1;
    end
    check(lows == CONV, "R2/R3 busy length", lows, CONV);
    byte_sel = sw;
    exp_q.push_back(lanes(s, sw));
    exp_tc_q.push_back(lanes(s ^ 16'h8000, sw));
    @(negedge clk);
    ->rd_ev;
    #1;
    byte_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ns, nl;
    rst_n = 1'b0; cs_n = 1'b1; rc_n = 1'b1; byte_sel = 1'b0; sample_in = 16'h0;
    repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R10 busy in reset", busy_n, 1);
    check(!short_o && !long_o, "R10 flags in reset", {short_o, long_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    check(data_oe == 1'b1, "R4 enable with cs low rc high", data_oe, 1);
    check(data_o == 16'h0, "R10 output register zero", data_o, 0);
    cs_n = 1'b1;
    @(negedge clk);
    check(data_oe == 1'b0 && data_o == 16'h0, "R4 disabled with cs high", data_o, 0);
    rc_n = 1'b0;
    @(negedge clk);
    check(data_oe == 1'b0 && busy_n == 1'b1, "R4 no start with cs high", {data_oe, busy_n}, 1);
    rc_n = 1'b1;

    convert(16'h1234, 6, 0, 16'h0000, 1'b0);
    convert(16'hABCD, 6, 0, 16'h1234, 1'b1);
    convert(16'h7F01, 5, 10, 16'hABCD, 1'b0);   // R3 restart attempt ignored
    convert(16'h00FF, 1, 0, 16'h7F01, 1'b1);

    ns = n_short; nl = n_long;
    convert(16'h5555, MINS - 1, 0, 16'h00FF, 1'b0);
    check(n_short == ns + 1, "R8 short strobe flagged", n_short - ns, 1);
    ns = n_short;
    convert(16'hAAAA, MINS, 0, 16'h5555, 1'b0);
    check(n_short == ns, "R8 minimum strobe not flagged", n_short - ns, 0);
    nl = n_long;
    convert(16'h8001, MAXL, 0, 16'hAAAA, 1'b0);
    check(n_long == nl, "R9 hold at limit not flagged", n_long - nl, 0);
    convert(16'h0102, MAXL + 1, 0, 16'h8001, 1'b1);
    check(n_long == nl + 1, "R9 long hold flagged", n_long - nl, 1);

    @(negedge clk); rc_n = 1'b0;
    @(negedge clk);
    check(data_oe == 1'b0 && data_o == 16'h0, "R4 bus off while rc low", data_o, 0);
    rc_n = 1'b1; cs_n = 1'b1;
    repeat (CONV + 2) @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule